// File: doc/BRIEF.md
# Data Object Mailbox Controller

This block is a small register file that lets a host exchange request and response data objects with on-chip protocol handlers, one 32-bit dword at a time. The host pushes request dwords into a write buffer, then sets a go bit. Dispatch compares the first request dword with a table of supported protocol headers. It also checks that the number of dwords received matches the length field carried in the second dword. If both pass, dispatch hands the request to the matching handler through a start/done port. The handler reads the request from the write buffer and appends its response to the read buffer.

On success the controller raises a ready flag. The host then reads the response one dword at a time through the read-data register. Writing that register steps to the next dword. Failed or malformed requests are dropped silently. Reading past the end of a response raises an error flag, which only an abort clears. An optional interrupt request is pulsed for one cycle when the interrupt status flag goes from 0 to 1.

Register addresses are dword indices:

| Index | Register |
|---|---|
| 0 | capability |
| 1 | control |
| 2 | status |
| 3 | write data |
| 4 | read data |

Top module: `objmbox_ctrl`

## Requirements
- R1: After reset, status and control read 0. The capability register reads bit 0 = interrupt supported and bits 11:1 = interrupt vector. A control read returns only the interrupt-enable bit (bit 1); abort (bit 0) and go (bit 31) always read 0.
- R2: Each full-dword write to index 3 stores the dword at the write count and increments the count. A write made once the count equals the buffer depth is dropped.
- R3: A control write with go (bit 31) pulses the handler start for one cycle. The start carries the index of the first protocol header equal to the first request dword. Status busy (bit 0) is set until the handler reports done.
- R4: Dispatch starts a handler only if the received dword count equals the low 18 bits of the second request dword. A value of zero there stands for 2^18 dwords.
- R5: A request with no matching header, a failed length check, or a handler done with the success flag low is dropped. Dropping empties both buffers and leaves ready clear.
- R6: A handler done with success sets ready (status bit 31). A full-dword read of index 4 returns the current response dword while ready is set and error is clear, and 0 otherwise.
- R7: A full-dword write to index 4 advances the read index. When the index reaches the response length, both buffers empty and ready clears. An advance past the response length sets error (status bit 2).
- R8: While error is set, go has no effect.
- R9: A control write with abort (bit 0) clears ready and error, empties both buffers and ends any dispatch. The rest of that write, including go and interrupt enable, is ignored.
- R10: Accesses to index 3 or 4 whose byte enables are not all set are ignored, and such reads of index 4 return 0.
- R11: When ready or error becomes set, interrupt status (status bit 1) is set and the interrupt output pulses for one cycle. This happens only if interrupts are supported and enabled and interrupt status was clear.
- R12: Writing 1 to status bit 1 clears interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register dword index |
| reg_be | input | 4 | Byte enables of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr and reg_be |
| irq | output | 1 | One-cycle interrupt request |
| hnd_start | output | 1 | One-cycle handler start |
| hnd_sel | output | SW | Index of the selected protocol |
| hnd_done | input | 1 | Handler finished |
| hnd_ok | input | 1 | Handler success, valid with hnd_done |
| hnd_req_len | output | CW | Number of request dwords held |
| hnd_raddr | input | AW | Request buffer read index |
| hnd_rdata | output | 32 | Request dword at hnd_raddr |
| hnd_push | input | 1 | Append a response dword |
| hnd_push_data | input | 32 | Response dword to append |

## Verification
Four kinds of request go through dispatch: a well-formed one, one whose length field disagrees with the dword count, one with an unknown header, and one whose handler fails. Only the first may reach ready; the other three must drop cleanly, and a later good request proves the buffers were emptied. Length fields with zero, or with junk in the upper bits, show whether the 18-bit decode is right. An overfilled buffer and partial-width mailbox accesses each feed a good request and show whether the extra dwords were dropped. Read-index stepping up to the end and then past it, with interrupt enable on, off, and with status still pending, shows when an interrupt may fire.

// File: rtl/objmbox_pkg.sv
package objmbox_pkg;

    // Register dword indices
    localparam logic [2:0] A_CAP  = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_WMB  = 3'd3;
    localparam logic [2:0] A_RMB  = 3'd4;

    // Control bits
    localparam int CTL_ABORT = 0;
    localparam int CTL_IEN   = 1;
    localparam int CTL_GO    = 31;

    // Status bits
    localparam int ST_BUSY = 0;
    localparam int ST_INT  = 1;
    localparam int ST_ERR  = 2;
    localparam int ST_RDY  = 31;

    localparam int LEN_BITS = 18;

    typedef enum logic {
        PH_IDLE,
        PH_RUN
    } phase_e;

endpackage

// File: rtl/objmbox_match.sv
module objmbox_match #(
    parameter int NPROT = 2,
    parameter logic [NPROT-1:0][31:0] PROT_HDR = '0,
    parameter int CW = 5,
    parameter int SW = 1
) (
    input  logic [31:0]                       hdr,
    input  logic [objmbox_pkg::LEN_BITS-1:0]  lenw,
    input  logic [CW-1:0]                     wcnt,
    output logic                              hit,
    output logic [SW-1:0]                     sel,
    output logic                              len_ok
);
    localparam int LB = objmbox_pkg::LEN_BITS;

    logic [NPROT-1:0] eq;
    logic [LB:0]      need;

    for (genvar i = 0; i < NPROT; i++) begin : g_cmp
        assign eq[i] = (hdr == PROT_HDR[i]);
    end

    // Lowest index wins
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NPROT - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                sel = SW'(i);
            end
        end
    end

    // A zero length field encodes the full 2^18 dword size
    assign need   = (lenw == '0) ? {1'b1, {LB{1'b0}}} : {1'b0, lenw};
    assign len_ok = (wcnt >= CW'(2)) && ((LB+1)'(wcnt) == need);

endmodule

// File: rtl/objmbox_dwbuf.sv
module objmbox_dwbuf #(
    parameter int DEPTH = 16,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/objmbox_ctrl.sv
module objmbox_ctrl #(
    parameter int DEPTH = 16,
    parameter int NPROT = 2,
    parameter logic [NPROT-1:0][31:0] PROT_HDR = {32'h0002_1AB4, 32'h0001_1AB4},
    parameter bit INT_SUPP = 1'b1,
    parameter logic [10:0] INT_VEC = 11'd5,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 3),
    localparam int SW = (NPROT > 1) ? $clog2(NPROT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [3:0]    reg_be,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          hnd_start,
    output logic [SW-1:0] hnd_sel,
    input  logic          hnd_done,
    input  logic          hnd_ok,
    output logic [CW-1:0] hnd_req_len,
    input  logic [AW-1:0] hnd_raddr,
    output logic [31:0]   hnd_rdata,
    input  logic          hnd_push,
    input  logic [31:0]   hnd_push_data
);
    import objmbox_pkg::*;

    typedef struct packed {
        phase_e              phase;
        logic [CW-1:0]       wcnt;
        logic [CW-1:0]       rlen;
        logic [CW-1:0]       ridx;
        logic [31:0]         hdr;
        logic [LEN_BITS-1:0] lenw;
        logic                ready;
        logic                err;
        logic                intst;
        logic                inten;
        logic                irq;
        logic                start;
        logic [SW-1:0]       sel;
    } st_t;

    st_t st_d, st_q;

    logic          wb_we, rb_we, clr, raise, full;
    logic          hit, len_ok;
    logic [SW-1:0] sel;
    logic [31:0]   rb_rdata;
    logic          stat_busy, stat_ready, stat_err, stat_int;

    objmbox_match #(
        .NPROT(NPROT), .PROT_HDR(PROT_HDR), .CW(CW), .SW(SW)
    ) u_match (
        .hdr(st_q.hdr), .lenw(st_q.lenw), .wcnt(st_q.wcnt),
        .hit(hit), .sel(sel), .len_ok(len_ok)
    );

    objmbox_dwbuf #(.DEPTH(DEPTH), .AW(AW)) u_wbuf (
        .clk(clk), .we(wb_we), .waddr(st_q.wcnt[AW-1:0]), .wdata(reg_wdata),
        .raddr(hnd_raddr), .rdata(hnd_rdata)
    );

    objmbox_dwbuf #(.DEPTH(DEPTH), .AW(AW)) u_rbuf (
        .clk(clk), .we(rb_we), .waddr(st_q.rlen[AW-1:0]), .wdata(hnd_push_data),
        .raddr(st_q.ridx[AW-1:0]), .rdata(rb_rdata)
    );

    assign full = (reg_be == 4'hF);

    always_comb begin
        st_d       = st_q;
        st_d.irq   = 1'b0;
        st_d.start = 1'b0;
        wb_we      = 1'b0;
        rb_we      = 1'b0;
        clr        = 1'b0;
        raise      = 1'b0;

        // Handler side
        if (st_q.phase == PH_RUN) begin
            if (hnd_push && (st_q.rlen < CW'(DEPTH))) begin
                rb_we     = 1'b1;
                st_d.rlen = st_q.rlen + 1'b1;
            end
            if (hnd_done) begin
                st_d.phase = PH_IDLE;
                if (hnd_ok) begin
                    st_d.ready = 1'b1;
                    raise      = 1'b1;
                end else begin
                    clr = 1'b1;
                end
            end
        end

        // Register side
        if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: begin
                    if (reg_be[0] && reg_wdata[CTL_ABORT]) begin
                        st_d.ready = 1'b0;
                        st_d.err   = 1'b0;
                        st_d.phase = PH_IDLE;
                        clr        = 1'b1;
                        raise      = 1'b0;
                        rb_we      = 1'b0;
                    end else begin
                        if (reg_be[3] && reg_wdata[CTL_GO] &&
                            st_q.phase == PH_IDLE && !st_q.err) begin
                            if (hit && len_ok) begin
                                st_d.phase = PH_RUN;
                                st_d.start = 1'b1;
                                st_d.sel   = sel;
                            end else begin
                                clr = 1'b1;
                            end
                        end
                        if (reg_be[0]) begin
                            st_d.inten = reg_wdata[CTL_IEN];
                        end
                    end
                end
                A_STAT: begin
                    if (reg_be[0] && reg_wdata[ST_INT]) begin
                        st_d.intst = 1'b0;
                    end
                end
                A_WMB: begin
                    if (full && (st_q.wcnt < CW'(DEPTH))) begin
                        wb_we     = 1'b1;
                        st_d.wcnt = st_q.wcnt + 1'b1;
                        if (st_q.wcnt == CW'(0)) st_d.hdr  = reg_wdata;
                        if (st_q.wcnt == CW'(1)) st_d.lenw = reg_wdata[LEN_BITS-1:0];
                    end
                end
                A_RMB: begin
                    if (full) begin
                        if (st_q.ridx <= st_q.rlen) begin
                            st_d.ridx = st_q.ridx + 1'b1;
                        end
                        if (st_q.ridx + 1'b1 == st_q.rlen) begin
                            clr        = 1'b1;
                            st_d.ready = 1'b0;
                        end else if (st_q.ridx >= st_q.rlen) begin
                            st_d.err = 1'b1;
                            raise    = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (clr) begin
            st_d.wcnt = '0;
            st_d.rlen = '0;
            st_d.ridx = '0;
        end

        if (raise && INT_SUPP && st_q.inten && !st_q.intst) begin
            st_d.intst = 1'b1;
            st_d.irq   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_busy  = (st_q.phase == PH_RUN);
    assign stat_ready = st_q.ready;
    assign stat_err   = st_q.err;
    assign stat_int   = st_q.intst;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CAP:  reg_rdata = {20'b0, INT_VEC, INT_SUPP};
            A_CTRL: reg_rdata[CTL_IEN] = st_q.inten;
            A_STAT: begin
                reg_rdata[ST_BUSY] = stat_busy;
                reg_rdata[ST_INT]  = stat_int;
                reg_rdata[ST_ERR]  = stat_err;
                reg_rdata[ST_RDY]  = stat_ready;
            end
            A_RMB:  if (full && stat_ready && !stat_err) reg_rdata = rb_rdata;
            default: ;
        endcase
    end

    assign irq         = st_q.irq;
    assign hnd_start   = st_q.start;
    assign hnd_sel     = st_q.sel;
    assign hnd_req_len = st_q.wcnt;

endmodule

// File: rtl/objmbox_chk.sv
module objmbox_chk (
    input logic clk,
    input logic rst_n,
    input logic abort_req,
    input logic irq,
    input logic hnd_start,
    input logic stat_busy,
    input logic stat_ready,
    input logic stat_err,
    input logic stat_int
);
    // R9
    abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (!stat_ready && !stat_err && !stat_busy));

    // R11
    irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_int && !$past(stat_int)));

    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hnd_start |-> (stat_busy && !$past(stat_busy)));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_err && !stat_busy) |=> !stat_busy);

endmodule

bind objmbox_ctrl objmbox_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .abort_req(reg_wr && reg_addr == 3'd1 && reg_be[0] && reg_wdata[0]),
    .irq(irq),
    .hnd_start(hnd_start),
    .stat_busy(stat_busy),
    .stat_ready(stat_ready),
    .stat_err(stat_err),
    .stat_int(stat_int)
);

// File: tb/objmbox_ctrl_tb.sv
module objmbox_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int DEPTH = 16;
    localparam logic [31:0] P0 = 32'h0001_1AB4;
    localparam logic [31:0] P1 = 32'h0002_1AB4;
    localparam logic [2:0] CAP = 3'd0, CTL = 3'd1, STA = 3'd2, WMB = 3'd3, RMB = 3'd4;
    localparam logic [31:0] S_RDY = 32'h8000_0000, S_INT = 32'h2, S_ERR = 32'h4, S_BUSY = 32'h1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [3:0] reg_be = 4'hF;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq, hnd_start, hnd_done = 1'b0, hnd_ok = 1'b0, hnd_push = 1'b0;
    logic [0:0] hnd_sel;
    logic [4:0] hnd_req_len;
    logic [3:0] hnd_raddr = '0;
    logic [31:0] hnd_rdata, hnd_push_data = '0;

    int n_tests = 0, n_fail = 0, irq_cnt = 0;
    logic ien = 1'b1;
    logic [31:0] r;

    objmbox_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .hnd_start(hnd_start), .hnd_sel(hnd_sel), .hnd_done(hnd_done), .hnd_ok(hnd_ok),
        .hnd_req_len(hnd_req_len), .hnd_raddr(hnd_raddr), .hnd_rdata(hnd_rdata),
        .hnd_push(hnd_push), .hnd_push_data(hnd_push_data)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) if (irq) irq_cnt++;

    // Handler model: protocol 0 echoes header, length 3 and payload+1; protocol 1 fails
    initial forever begin
        @(negedge clk);
        if (hnd_start) begin
            if (hnd_sel == 1'b0) begin
                hnd_raddr = 4'd2;
                #1;
                r = hnd_rdata + 1;
                hnd_push = 1'b1; hnd_push_data = P0;
                @(negedge clk); hnd_push_data = 32'd3;
                @(negedge clk); hnd_push_data = r;
                @(negedge clk); hnd_push = 1'b0; hnd_done = 1'b1; hnd_ok = 1'b1;
            end else begin
                @(negedge clk); hnd_done = 1'b1; hnd_ok = 1'b0;
            end
            @(negedge clk); hnd_done = 1'b0; hnd_ok = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'hF;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v, input logic [3:0] be = 4'hF);
        reg_addr = a; reg_be = be;
        #1 v = reg_rdata;
        reg_be = 4'hF;
    endtask

    task automatic go();
        wr(CTL, {1'b1, 29'b0, ien, 1'b0});
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] h, input logic [31:0] len, input int n);
        wr(WMB, h);
        wr(WMB, len);
        for (int i = 2; i < n; i++) wr(WMB, 32'h40 + i);
        go();
    endtask

    task automatic abort();
        wr(CTL, {30'b0, ien, 1'b1});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(CAP, v); check("R1 cap", v, 32'h0000_000B);
        rd(STA, v); check("R1 status", v, 0);
        rd(CTL, v); check("R1 ctrl", v, 0);
        rd(RMB, v); check("R6 empty read", v, 0);
    endtask

    task automatic t_good();
        logic [31:0] v;
        int c0;
        ien = 1'b1; c0 = irq_cnt;
        send(P0, 32'd3, 3);
        rd(STA, v); check("R3 busy", v, S_BUSY);
        settle();
        rd(STA, v); check("R6 ready", v, S_RDY | S_INT);
        check("R11 irq once", irq_cnt - c0, 1);
        rd(RMB, v); check("R6 dw0", v, P0);
        wr(RMB, 0); rd(RMB, v); check("R7 dw1", v, 32'd3);
        wr(RMB, 0); rd(RMB, v); check("R7 dw2", v, 32'h43);
        wr(RMB, 0); rd(STA, v); check("R7 end clears ready", v, S_INT);
        wr(STA, 32'h2); rd(STA, v); check("R12 int cleared", v, 0);
    endtask

    task automatic t_drops();
        logic [31:0] v;
        send(P0, 32'd4, 3); settle();
        rd(STA, v); check("R4 len mismatch", v, 0);
        send(32'h0003_1AB4, 32'd3, 3); settle();
        rd(STA, v); check("R5 no match", v, 0);
        send(P1, 32'd2, 2); settle();
        rd(STA, v); check("R5 handler fail", v, 0);
        send(P0, 32'hFFFC_0000, 2); settle();
        rd(STA, v); check("R4 zero means 2^18", v, 0);
        send(P0, 32'd3, 3); settle();
        rd(STA, v); check("R5 buffers emptied", v, S_RDY | S_INT);
        rd(RMB, v); check("R5 fresh response", v, P0);
        abort(); wr(STA, 32'h2);
        send(P0, 32'hFFFC_0002, 2); settle();
        rd(STA, v); check("R4 upper bits ignored", v, S_RDY | S_INT);
        abort(); wr(STA, 32'h2);
    endtask

    task automatic t_partial_overflow();
        logic [31:0] v;
        wr(WMB, P0);
        wr(WMB, 32'hDEAD, 4'h3);
        wr(WMB, 32'd3);
        wr(WMB, 32'h50);
        go(); settle();
        rd(STA, v); check("R10 partial write ignored", v, S_RDY | S_INT);
        rd(RMB, v, 4'h1); check("R10 partial read", v, 0);
        wr(RMB, 0, 4'h1);
        rd(RMB, v); check("R10 partial advance ignored", v, P0);
        rd(RMB, v); abort(); wr(STA, 32'h2);
        wr(WMB, P0); wr(WMB, DEPTH);
        for (int i = 2; i < DEPTH + 2; i++) wr(WMB, 32'h60 + i);
        go(); settle();
        rd(STA, v); check("R2 overflow dropped", v, S_RDY | S_INT);
        wr(RMB, 0); wr(RMB, 0);
        rd(RMB, v); check("R2 stored payload", v, 32'h63);
        abort(); wr(STA, 32'h2);
    endtask

    task automatic t_error();
        logic [31:0] v;
        int c0;
        c0 = irq_cnt;
        wr(RMB, 0);
        rd(STA, v); check("R7 underflow error", v, S_ERR | S_INT);
        check("R11 irq on error", irq_cnt - c0, 1);
        send(P0, 32'd3, 3);
        rd(STA, v); check("R8 go blocked", v, S_ERR | S_INT);
        rd(RMB, v); check("R6 read under error", v, 0);
        abort();
        rd(STA, v); check("R9 abort clears error", v, S_INT);
        send(P0, 32'd3, 3); settle();
        c0 = irq_cnt;
        wr(RMB, 0); wr(RMB, 0); wr(RMB, 0); wr(RMB, 0);
        rd(STA, v); check("R11 no irq while pending", v, S_ERR | S_INT);
        check("R11 irq count", irq_cnt - c0, 0);
        abort(); wr(STA, 32'h2);
    endtask

    task automatic t_noint_abort();
        logic [31:0] v;
        int c0;
        ien = 1'b0; c0 = irq_cnt;
        send(P0, 32'd3, 3); settle();
        rd(STA, v); check("R11 disabled", v, S_RDY);
        check("R11 disabled irq", irq_cnt - c0, 0);
        wr(CTL, 32'h8000_0003);
        rd(STA, v); check("R9 abort wins", v, 0);
        rd(CTL, v); check("R9 ien untouched", v, 0);
        rd(RMB, v); check("R9 read after abort", v, 0);
        wr(CTL, 32'h8000_0002);
        rd(CTL, v); check("R1 ctrl readback", v, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_good();
        t_drops();
        t_partial_overflow();
        t_error();
        t_noint_abort();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog got=hang exp=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule